// File: doc/BRIEF.md
# Integer Shift and Rotate Unit

This is a purely combinational unit for the register-register group of a 32-bit load/store integer core. It receives the instruction word and the two source operand values. It returns the word to be written to the destination register. The unit covers four shift kinds: logical left, logical right, arithmetic right and rotate right. The shift amount comes either from the instruction's shift-amount field or from the low five bits of the first source operand.

Rotate right has no function code of its own. The immediate form reuses the logical-right code, and instruction bit 21 selects rotate over shift. The variable form reuses the variable-logical-right code, and instruction bit 6 selects rotate. The unit also recognises three hint encodings that sit inside the left-shift-by-immediate code: the plain no-op, the superscalar no-op and the execution hazard barrier. Any instruction outside the shift group raises a foreign flag, so the surrounding datapath can take its result from elsewhere.

Top module: `shift_unit`

## Requirements
- R1: Opcode bits 31:26 = 0 with function bits 5:0 = 0x00 gives rt shifted left by the shift-amount field (bits 10:6), filling with zeros.
- R2: Function 0x02 with bit 21 = 0 gives rt shifted right logically by the shift-amount field.
- R3: Function 0x02 with bit 21 = 1 gives rt rotated right by the shift-amount field, that is (rt << (32 - n)) | (rt >> n).
- R4: Function 0x03 gives rt shifted right by the shift-amount field, filling with copies of rt bit 31.
- R5: Function 0x04 gives rt shifted left logically by rs bits 4:0.
- R6: Function 0x06 gives rt shifted right logically by rs bits 4:0 when bit 6 = 0, and rotated right by rs bits 4:0 when bit 6 = 1.
- R7: Function 0x07 gives rt shifted right arithmetically by rs bits 4:0.
- R8: For the variable forms, rs bits 31:5 have no effect on the result.
- R9: Instruction word 0x00000000 raises only the no-op flag, 0x00000040 raises only the superscalar no-op flag, and 0x000000C0 raises only the hazard-barrier flag. In all three cases the result is zero. Any other left-shift encoding raises no hint flag.
- R10: A nonzero opcode, or function code 0x01 or 0x05 or any code of 0x08 and above, raises the foreign flag and drives the result to zero. Shift encodings never raise the foreign flag.
- R11: A rotate by an amount of 0, in either the immediate or the variable form, returns rt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | First source operand value; its low bits give the variable amount |
| rt_val_i | input | 32 | Second source operand value; the data that is shifted |
| result_o | output | 32 | Value for the destination register |
| is_nop_o | output | 1 | Plain no-op encoding seen |
| is_ssnop_o | output | 1 | Superscalar no-op encoding seen |
| is_ehb_o | output | 1 | Execution hazard barrier encoding seen |
| not_mine_o | output | 1 | Instruction is not a shift or rotate |

## Verification
Hint detection and the left-shift datapath act on the same function code in the same evaluation, so the hint override is the place where they can collide. The bench drives each of the three hint words with a nonzero rt operand value and expects a zero result. It also drives near-miss words that differ only in the rt field or the shift-amount field, and expects an ordinary shift result with no flag. The rotate selection bits collide with the shift path in the same way. For that reason, both logical-right codes are driven with the selection bit set and cleared over random operands, and each result is judged against a bench-side model.

// File: rtl/shift_pkg.sv
package shift_pkg;
    localparam int FIELD_W = 5;
    localparam int FUNC_W  = 6;

    localparam logic [FUNC_W-1:0] FN_SLL_I = 6'h00;
    localparam logic [FUNC_W-1:0] FN_SRL_I = 6'h02;
    localparam logic [FUNC_W-1:0] FN_SRA_I = 6'h03;
    localparam logic [FUNC_W-1:0] FN_SLL_V = 6'h04;
    localparam logic [FUNC_W-1:0] FN_SRL_V = 6'h06;
    localparam logic [FUNC_W-1:0] FN_SRA_V = 6'h07;

    localparam int IMM_ROT_BIT = 21;
    localparam int VAR_ROT_BIT = 6;

    typedef enum logic [1:0] {
        SK_LEFT  = 2'd0,
        SK_RIGHT = 2'd1,
        SK_ARITH = 2'd2,
        SK_ROT   = 2'd3
    } shift_kind_e;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
    import shift_pkg::*;
#(
    parameter int AMT_W = 5
) (
    input  logic [31:0]      instr_i,
    input  logic [AMT_W-1:0] rs_amt_i,
    output shift_kind_e      kind_o,
    output logic [AMT_W-1:0] amt_o,
    output logic             foreign_o
);
    logic [FUNC_W-1:0]  func;
    logic [AMT_W-1:0]   imm_amt;
    logic               opc_zero;

    assign func     = instr_i[FUNC_W-1:0];
    assign imm_amt  = instr_i[6 +: AMT_W];
    assign opc_zero = (instr_i[31:26] == 6'd0);

    always_comb begin
        kind_o    = SK_LEFT;
        amt_o     = imm_amt;
        foreign_o = 1'b0;
        unique case (func)
            FN_SLL_I: kind_o = SK_LEFT;
            FN_SRL_I: kind_o = instr_i[IMM_ROT_BIT] ? SK_ROT : SK_RIGHT;
            FN_SRA_I: kind_o = SK_ARITH;
            FN_SLL_V: begin kind_o = SK_LEFT;  amt_o = rs_amt_i; end
            FN_SRL_V: begin
                kind_o = instr_i[VAR_ROT_BIT] ? SK_ROT : SK_RIGHT;
                amt_o  = rs_amt_i;
            end
            FN_SRA_V: begin kind_o = SK_ARITH; amt_o = rs_amt_i; end
            default:  foreign_o = 1'b1;
        endcase
        if (!opc_zero) foreign_o = 1'b1;
    end
endmodule

// File: rtl/shift_hint.sv
module shift_hint (
    input  logic [31:0] instr_i,
    output logic        nop_o,
    output logic        ssnop_o,
    output logic        ehb_o
);
    logic upper_clear;

    // everything except the shift-amount field must be zero
    assign upper_clear = (instr_i[31:11] == 21'd0) && (instr_i[5:0] == 6'd0);

    always_comb begin
        nop_o   = upper_clear && (instr_i[10:6] == 5'd0);
        ssnop_o = upper_clear && (instr_i[10:6] == 5'd1);
        ehb_o   = upper_clear && (instr_i[10:6] == 5'd3);
    end

    always_comb begin
        if (!$isunknown(instr_i)) begin
            AST_HINT_EXCLUSIVE: assert ($onehot0({nop_o, ssnop_o, ehb_o}))
                else $error("hint flags overlap"); // R9
        end
    end
endmodule

// File: rtl/shift_barrel.sv
module shift_barrel
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  shift_kind_e       kind_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] head;
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] rev_out;
    logic [DATA_W-1:0] tail;
    logic              is_left;
    logic              is_rot;
    logic              sign_fill;

    assign is_left   = (kind_i == SK_LEFT);
    assign is_rot    = (kind_i == SK_ROT);
    assign sign_fill = (kind_i == SK_ARITH) && data_i[DATA_W-1];

    // a left shift runs through the right-shift stages on the mirrored word
    for (genvar b = 0; b < DATA_W; b++) begin : g_mirror
        assign rev_in[b]  = data_i[DATA_W-1-b];
        assign rev_out[b] = tail[DATA_W-1-b];
    end

    assign head = is_left ? rev_in : data_i;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [DATA_W-1:0] in_w;
        logic [DATA_W-1:0] out_w;
        logic [STEP-1:0]   fill;
        if (k == 0) begin : g_first
            assign in_w = head;
        end else begin : g_next
            assign in_w = g_stage[k-1].out_w;
        end
        assign fill  = is_rot ? in_w[STEP-1:0] : {STEP{sign_fill}};
        assign out_w = amt_i[k] ? {fill, in_w[DATA_W-1:STEP]} : in_w;
    end

    assign tail   = g_stage[AMT_W-1].out_w;
    assign data_o = is_left ? rev_out : tail;

    always_comb begin
        if (!$isunknown({data_i, amt_i, kind_i})) begin
            if (amt_i == '0) begin
                AST_ZERO_AMT_IDENT: assert (data_o == data_i)
                    else $error("zero amount altered data"); // R11
            end
            if (kind_i == SK_ROT) begin
                AST_ROT_KEEPS_BITS: assert ($countones(data_o) == $countones(data_i))
                    else $error("rotate lost bits"); // R3
            end
        end
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [31:0]       instr_i,
    input  logic [DATA_W-1:0] rs_val_i,
    input  logic [DATA_W-1:0] rt_val_i,
    output logic [DATA_W-1:0] result_o,
    output logic              is_nop_o,
    output logic              is_ssnop_o,
    output logic              is_ehb_o,
    output logic              not_mine_o
);
    shift_kind_e       kind;
    logic [AMT_W-1:0]  amt;
    logic              foreign;
    logic [DATA_W-1:0] shifted;
    logic              any_hint;

    shift_decode #(.AMT_W(AMT_W)) u_dec (
        .instr_i  (instr_i),
        .rs_amt_i (rs_val_i[AMT_W-1:0]),
        .kind_o   (kind),
        .amt_o    (amt),
        .foreign_o(foreign)
    );

    shift_hint u_hint (
        .instr_i(instr_i),
        .nop_o  (is_nop_o),
        .ssnop_o(is_ssnop_o),
        .ehb_o  (is_ehb_o)
    );

    shift_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_bar (
        .data_i(rt_val_i),
        .amt_i (amt),
        .kind_i(kind),
        .data_o(shifted)
    );

    assign any_hint   = is_nop_o | is_ssnop_o | is_ehb_o;
    assign not_mine_o = foreign;
    assign result_o   = (foreign || any_hint) ? '0 : shifted;

    always_comb begin
        if (!$isunknown({instr_i, rs_val_i, rt_val_i})) begin
            if (not_mine_o) begin
                AST_FOREIGN_ZERO: assert (result_o == '0)
                    else $error("foreign result nonzero"); // R10
            end
            if (any_hint) begin
                AST_HINT_IS_SHIFT: assert (!not_mine_o)
                    else $error("hint marked foreign"); // R9
            end
            if (instr_i[31:26] == 6'd0 && instr_i[5:0] == FN_SLL_V) begin
                AST_VAR_AMT_LOW: assert (amt == rs_val_i[AMT_W-1:0])
                    else $error("variable amount wrong"); // R8
            end
        end
    end
endmodule

// File: tb/shift_unit_test.sv
module shift_unit_test;
    logic        clk = 1'b0;
    logic [31:0] instr, rs_v, rt_v, res;
    logic        f_nop, f_ss, f_ehb, f_nm;
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    shift_unit uut (
        .instr_i   (instr),
        .rs_val_i  (rs_v),
        .rt_val_i  (rt_v),
        .result_o  (res),
        .is_nop_o  (f_nop),
        .is_ssnop_o(f_ss),
        .is_ehb_o  (f_ehb),
        .not_mine_o(f_nm)
    );

    function automatic logic [31:0] rot_r(input logic [31:0] v, input logic [4:0] n);
        logic [63:0] t;
        t = {v, v} >> n;
        return t[31:0];
    endfunction

    function automatic logic [35:0] model(input logic [31:0] i, input logic [31:0] rs,
                                          input logic [31:0] rt);
        logic [31:0] r;
        logic [3:0]  fl;
        logic [4:0]  sa, va;
        sa = i[10:6];
        va = rs[4:0];
        r  = 32'd0;
        fl = 4'b0000;
        if (i == 32'h0)           fl = 4'b1000;
        else if (i == 32'h40)     fl = 4'b0100;
        else if (i == 32'hC0)     fl = 4'b0010;
        else if (i[31:26] != 0)   fl = 4'b0001;
        else begin
            case (i[5:0])
                6'h00: r = rt << sa;
                6'h02: r = i[21] ? rot_r(rt, sa) : rt >> sa;
                6'h03: r = 32'($signed(rt) >>> sa);
                6'h04: r = rt << va;
                6'h06: r = i[6] ? rot_r(rt, va) : rt >> va;
                6'h07: r = 32'($signed(rt) >>> va);
                default: fl = 4'b0001;
            endcase
        end
        return {fl, r};
    endfunction

    task automatic run(input string tag, input logic [31:0] i, input logic [31:0] rs,
                       input logic [31:0] rt);
        logic [35:0] e;
        @(negedge clk);
        instr = i; rs_v = rs; rt_v = rt;
        #2;
        e = model(i, rs, rt);
        checks++;
        if (res !== e[31:0]) begin
            errors++;
            $display("FAIL %s result instr=%h act=%h exp=%h", tag, i, res, e[31:0]);
        end
        checks++;
        if ({f_nop, f_ss, f_ehb, f_nm} !== e[35:32]) begin
            errors++;
            $display("FAIL %s flags instr=%h act=%b exp=%b", tag, i,
                     {f_nop, f_ss, f_ehb, f_nm}, e[35:32]);
        end
    endtask

    function automatic logic [31:0] enc(input logic [5:0] fn, input logic [4:0] sa,
                                        input logic rbit21);
        return {6'd0, 4'd0, rbit21, 5'd9, 5'd10, sa, fn};
    endfunction

    initial begin
        instr = 0; rs_v = 0; rt_v = 0;
        void'($urandom(32'd4242));
        // initial all-zero state reads as the plain no-op: R9
        run("R9", 32'h0, 32'h0, 32'h0);
        run("R1", enc(6'h00, 5'd4, 1'b0), 0, 32'h8000_00F1);
        run("R1", enc(6'h00, 5'd31, 1'b0), 0, 32'h0000_0003);
        run("R2", enc(6'h02, 5'd31, 1'b0), 0, 32'hFFFF_FFFF);
        run("R3", enc(6'h02, 5'd8, 1'b1), 0, 32'h1234_5678);
        run("R3", enc(6'h02, 5'd31, 1'b1), 0, 32'h8000_0001);
        run("R11", enc(6'h02, 5'd0, 1'b1), 0, 32'hDEAD_BEEF);
        run("R4", enc(6'h03, 5'd31, 1'b0), 0, 32'h8000_0000);
        run("R4", enc(6'h03, 5'd4, 1'b0), 0, 32'h7000_0000);
        run("R5", enc(6'h04, 5'd0, 1'b0), 32'h0000_0007, 32'h0000_0101);
        run("R6", enc(6'h06, 5'd0, 1'b0), 32'h0000_0010, 32'hF000_0000);
        run("R6", enc(6'h06, 5'd1, 1'b0), 32'h0000_0004, 32'h0000_00AB);
        run("R11", enc(6'h06, 5'd1, 1'b0), 32'hFFFF_FFE0, 32'hCAFE_F00D);
        run("R7", enc(6'h07, 5'd0, 1'b0), 32'h0000_001F, 32'h8000_1234);
        run("R8", enc(6'h04, 5'd0, 1'b0), 32'hFFFF_FFE3, 32'h0000_0001);
        run("R8", enc(6'h07, 5'd0, 1'b0), 32'h8000_0022, 32'hF000_0000);
        run("R9", 32'h0000_0040, 0, 32'hFFFF_FFFF);
        run("R9", 32'h0000_00C0, 0, 32'hFFFF_FFFF);
        run("R9", 32'h0001_0040, 0, 32'h0000_0005);
        run("R9", 32'h0000_0080, 0, 32'h0000_0005);
        run("R10", 32'h0400_0002, 0, 32'h1111_1111);
        run("R10", 32'h0000_0001, 0, 32'h1111_1111);
        run("R10", 32'h0000_0005, 0, 32'h1111_1111);
        run("R10", 32'h0000_0020, 0, 32'h1111_1111);
        for (int n = 0; n < 1500; n++) begin
            logic [5:0]  fn;
            logic [31:0] w;
            case ($urandom_range(0, 9))
                0: fn = 6'h00; 1: fn = 6'h02; 2: fn = 6'h03; 3: fn = 6'h04;
                4: fn = 6'h06; 5: fn = 6'h07; 6: fn = 6'h02; 7: fn = 6'h06;
                default: fn = 6'($urandom);
            endcase
            w = $urandom;
            w[5:0] = fn;
            if ($urandom_range(0, 7) != 0) w[31:26] = 6'd0;
            run("R1-R11-random", w, $urandom, $urandom);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule